// File: doc/BRIEF.md
# Multicycle Eight-Bit Processor Core

This block is a small programmable core that runs a seven-operation instruction set in which every instruction is sixteen bits wide. Instructions come from an external instruction store that is read one whole instruction per address. Operands live in sixteen 8-bit general registers and in a 256-byte data store inside the block. A sequencer carries each instruction through five one-clock phases: fetch, decode, operand read, execute and write-back. As a result, every legal instruction occupies exactly five clocks.

The surrounding logic supplies the program through the instruction port and sets a program-length input. It then releases reset and waits for the core to stop. The core stops with `done` when the program counter reaches the length, or with `halted` when it decodes an opcode that is not defined. A combinational debug port reads any register or data byte, so the final machine state can be compared against a reference model.

Top module: `mc8_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0, clears all registers and every data byte, returns the sequencer to fetch, and drives `done` and `halted` low.
- R2: Instruction encoding: bits 15:12 hold the opcode, bits 11:8 name register Rn, bits 7:0 form the second byte. Opcode 0x0 loads Rn from the data byte at the address in the second byte. Opcode 0x1 writes Rn to that address.
- R3: Opcode 0x2 writes register Rm (bits 7:4) to the data byte whose address is held in Rn. This covers address 0xFF.
- R4: Opcode 0x3 loads the second byte into Rn.
- R5: Opcode 0x4 sets Rn to Rn+Rm and opcode 0x5 sets Rn to Rn-Rm, where Rm is given by bits 7:4. Both results wrap modulo 256.
- R6: Opcode 0x6 sets the program counter to the branch's own address plus the second byte, read as a signed two's-complement value and wrapped to the counter width, when Rn is zero. Otherwise the counter advances by one.
- R7: Each legal instruction takes exactly five clocks. For a program that executes N instructions and ends by length, `done` is seen high after 5N+1 rising edges following reset release. The program counter never changes twice within five clocks.
- R8: Opcodes 0x7 to 0xF raise `halted` in the decode phase and change no register, byte or program counter. If N legal instructions precede the illegal one, `halted` is seen after 5N+2 edges. It stays high until reset.
- R9: When the program counter is not below `prog_len` at fetch, `done` rises, and the core stays stopped with the counter held until reset. `done` and `halted` are never high together.
- R10: The debug port returns register `dbg_addr[3:0]` when `dbg_mem_sel` is 0 and data byte `dbg_addr` when it is 1. The read is combinational and has no effect on execution.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_len | input | PC_W+1 | Number of instruction words; execution stops when the counter reaches it |
| imem_addr | output | PC_W | Program counter, the address of the instruction being fetched |
| imem_data | input | 16 | Instruction word at `imem_addr`, returned in the same cycle |
| dbg_mem_sel | input | 1 | Debug source: 0 register file, 1 data store |
| dbg_addr | input | 8 | Debug register index or data address |
| dbg_data | output | 8 | Debug read value |
| done | output | 1 | Program ran to its length; sticky until reset |
| halted | output | 1 | Illegal opcode seen; sticky until reset |

## Verification
A wrong opcode decode or a misrouted register nibble leaves a wrong value in a register or data byte, which is visible on the debug port once the core stops. A wrong branch sum or a wrong not-taken increment shows up directly on `imem_addr` at the next fetch and changes the stop point. A sequencer that skips or repeats a phase moves the edge on which `done` or `halted` appears by at least one clock. Because a reference model predicts that edge exactly, such a fault is caught within the first program.

// File: rtl/mc8_pkg.sv
package mc8_pkg;
   typedef logic [3:0] opc_t;

   localparam opc_t OPC_LDD = 4'h0;
   localparam opc_t OPC_STD = 4'h1;
   localparam opc_t OPC_STI = 4'h2;
   localparam opc_t OPC_LDI = 4'h3;
   localparam opc_t OPC_ADD = 4'h4;
   localparam opc_t OPC_SUB = 4'h5;
   localparam opc_t OPC_BRZ = 4'h6;

   typedef enum logic [2:0] {
      PH_FETCH, PH_DECODE, PH_OPND, PH_EXEC, PH_WBACK, PH_DONE, PH_HALT
   } phase_e;
endpackage

// File: rtl/mc8_regfile.sv
module mc8_regfile #(
   parameter int W     = 8,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [AW-1:0] ra_idx,
   input  logic [AW-1:0] rb_idx,
   input  logic [AW-1:0] dbg_idx,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [W-1:0]  wd,
   output logic [W-1:0]  ra_q,
   output logic [W-1:0]  rb_q,
   output logic [W-1:0]  dbg_q
);
   logic [W-1:0] rd_arr [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_reg
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
         if (rst)
            q <= '0;
         else if (we && wa == AW'(i))
            q <= wd;
      end
      assign rd_arr[i] = q;
   end

   assign ra_q  = rd_arr[ra_idx];
   assign rb_q  = rd_arr[rb_idx];
   assign dbg_q = rd_arr[dbg_idx];
endmodule

// File: rtl/mc8_dmem.sv
module mc8_dmem #(
   parameter int W     = 8,
   parameter int AW    = 8,
   localparam int DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [AW-1:0] rd_addr,
   output logic [W-1:0]  rd_q,
   input  logic          we,
   input  logic [AW-1:0] wr_addr,
   input  logic [W-1:0]  wr_d,
   input  logic [AW-1:0] dbg_addr,
   output logic [W-1:0]  dbg_q
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[wr_addr] <= wr_d;
      end
   end

   assign rd_q  = mem[rd_addr];
   assign dbg_q = mem[dbg_addr];
endmodule

// File: rtl/mc8_alu.sv
module mc8_alu
   import mc8_pkg::*;
#(
   parameter int W = 8
) (
   input  opc_t         op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] imm,
   input  logic [W-1:0] mem,
   output logic [W-1:0] res
);
   always_comb begin
      case (op)
         OPC_LDD: res = mem;
         OPC_LDI: res = imm;
         OPC_ADD: res = a + b;
         OPC_SUB: res = a - b;
         default: res = a;
      endcase
   end
endmodule

// File: rtl/mc8_ctrl.sv
module mc8_ctrl
   import mc8_pkg::*;
#(
   parameter int W    = 8,
   parameter int PC_W = 10,
   localparam int IW  = 2 * W
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [PC_W:0] prog_len,
   input  logic [IW-1:0] imem_data,
   input  logic [W-1:0]  ra_q,
   input  logic [W-1:0]  rb_q,
   input  logic [W-1:0]  dm_q,
   input  logic [W-1:0]  alu_res,
   output logic [3:0]    rn_idx,
   output logic [3:0]    rm_idx,
   output logic [W-1:0]  dm_rd_addr,
   output logic          rf_we,
   output logic [W-1:0]  rf_wd,
   output logic          dm_we,
   output logic [W-1:0]  dm_wa,
   output logic [W-1:0]  dm_wd,
   output opc_t          alu_op,
   output logic [W-1:0]  alu_a,
   output logic [W-1:0]  alu_b,
   output logic [W-1:0]  alu_imm,
   output logic [W-1:0]  alu_mem,
   output logic [PC_W-1:0] pc,
   output logic          done,
   output logic          halted
);
   phase_e       phase;
   logic [IW-1:0] ir;
   logic [W-1:0] opa, opb, mdr, res;
   logic         take;

   opc_t         opc;
   logic [W-1:0] sb;

   assign opc    = ir[IW-1 -: 4];
   assign rn_idx = ir[IW-5 -: 4];
   assign sb     = ir[W-1:0];
   assign rm_idx = sb[W-1 -: 4];

   always_ff @(posedge clk) begin
      if (rst) begin
         phase <= PH_FETCH;
         pc    <= '0;
         ir    <= '0;
         opa   <= '0;
         opb   <= '0;
         mdr   <= '0;
         res   <= '0;
         take  <= 1'b0;
      end else begin
         case (phase)
            PH_FETCH: begin
               if ({1'b0, pc} >= prog_len) begin
                  phase <= PH_DONE;
               end else begin
                  ir    <= imem_data;
                  phase <= PH_DECODE;
               end
            end
            PH_DECODE: begin
               if (opc > OPC_BRZ) begin
                  phase <= PH_HALT;
               end else begin
                  opa   <= ra_q;
                  opb   <= rb_q;
                  phase <= PH_OPND;
               end
            end
            PH_OPND: begin
               mdr   <= dm_q;
               phase <= PH_EXEC;
            end
            PH_EXEC: begin
               res   <= alu_res;
               take  <= (opc == OPC_BRZ) && (opa == '0);
               phase <= PH_WBACK;
            end
            PH_WBACK: begin
               pc    <= take ? pc + PC_W'(signed'(sb)) : pc + PC_W'(1);
               phase <= PH_FETCH;
            end
            default: phase <= phase;
         endcase
      end
   end

   assign dm_rd_addr = sb;
   assign alu_op  = opc;
   assign alu_a   = opa;
   assign alu_b   = opb;
   assign alu_imm = sb;
   assign alu_mem = mdr;

   always_comb begin
      rf_we = (phase == PH_WBACK) &&
              (opc == OPC_LDD || opc == OPC_LDI || opc == OPC_ADD || opc == OPC_SUB);
      rf_wd = res;
      dm_we = (phase == PH_WBACK) && (opc == OPC_STD || opc == OPC_STI);
      dm_wa = (opc == OPC_STI) ? opa : sb;
      dm_wd = (opc == OPC_STI) ? opb : opa;
   end

   assign done   = (phase == PH_DONE);
   assign halted = (phase == PH_HALT);
endmodule

// File: rtl/mc8_core.sv
module mc8_core
   import mc8_pkg::*;
#(
   parameter int W       = 8,
   parameter int REG_CNT = 16,
   parameter int DMEM_AW = 8,
   parameter int PC_W    = 10,
   localparam int REG_AW = $clog2(REG_CNT),
   localparam int IW     = 2 * W
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [PC_W:0]   prog_len,
   output logic [PC_W-1:0] imem_addr,
   input  logic [IW-1:0]   imem_data,
   input  logic            dbg_mem_sel,
   input  logic [W-1:0]    dbg_addr,
   output logic [W-1:0]    dbg_data,
   output logic            done,
   output logic            halted
);
   if (W != 8) begin : g_bad_w
      $error("mc8_core: encoding needs W == 8");
   end
   if (REG_CNT < 2 || REG_CNT > 16 || (REG_CNT & (REG_CNT - 1)) != 0) begin : g_bad_regs
      $error("mc8_core: REG_CNT must be a power of two from 2 to 16");
   end
   if (DMEM_AW < 1 || DMEM_AW > W) begin : g_bad_dmem
      $error("mc8_core: DMEM_AW must lie in 1..W");
   end
   if (PC_W < W) begin : g_bad_pc
      $error("mc8_core: PC_W must be at least W");
   end

   logic [3:0]   rn_idx, rm_idx;
   logic [W-1:0] ra_q, rb_q, rf_wd, rf_dbg_q;
   logic         rf_we, dm_we;
   logic [W-1:0] dm_rd_addr, dm_q, dm_wa, dm_wd, dm_dbg_q;
   opc_t         alu_op;
   logic [W-1:0] alu_a, alu_b, alu_imm, alu_mem, alu_res;

   mc8_ctrl #(.W(W), .PC_W(PC_W)) i_ctrl (
      .clk(clk), .rst(rst), .prog_len(prog_len), .imem_data(imem_data),
      .ra_q(ra_q), .rb_q(rb_q), .dm_q(dm_q), .alu_res(alu_res),
      .rn_idx(rn_idx), .rm_idx(rm_idx), .dm_rd_addr(dm_rd_addr),
      .rf_we(rf_we), .rf_wd(rf_wd), .dm_we(dm_we), .dm_wa(dm_wa), .dm_wd(dm_wd),
      .alu_op(alu_op), .alu_a(alu_a), .alu_b(alu_b), .alu_imm(alu_imm),
      .alu_mem(alu_mem), .pc(imem_addr), .done(done), .halted(halted)
   );

   mc8_regfile #(.W(W), .DEPTH(REG_CNT)) i_rf (
      .clk(clk), .rst(rst),
      .ra_idx(rn_idx[REG_AW-1:0]), .rb_idx(rm_idx[REG_AW-1:0]),
      .dbg_idx(dbg_addr[REG_AW-1:0]),
      .we(rf_we), .wa(rn_idx[REG_AW-1:0]), .wd(rf_wd),
      .ra_q(ra_q), .rb_q(rb_q), .dbg_q(rf_dbg_q)
   );

   mc8_dmem #(.W(W), .AW(DMEM_AW)) i_dm (
      .clk(clk), .rst(rst),
      .rd_addr(dm_rd_addr[DMEM_AW-1:0]), .rd_q(dm_q),
      .we(dm_we), .wr_addr(dm_wa[DMEM_AW-1:0]), .wr_d(dm_wd),
      .dbg_addr(dbg_addr[DMEM_AW-1:0]), .dbg_q(dm_dbg_q)
   );

   mc8_alu #(.W(W)) i_alu (
      .op(alu_op), .a(alu_a), .b(alu_b), .imm(alu_imm), .mem(alu_mem), .res(alu_res)
   );

   assign dbg_data = dbg_mem_sel ? dm_dbg_q : rf_dbg_q;
endmodule

// File: rtl/mc8_chk.sv
module mc8_chk #(
   parameter int PC_W = 10
) (
   input logic            clk,
   input logic            rst,
   input logic [PC_W-1:0] imem_addr,
   input logic            done,
   input logic            halted
);
   logic [PC_W-1:0] prev_pc;
   logic [2:0]      since;

   always_ff @(posedge clk) begin
      prev_pc <= imem_addr;
      if (rst)
         since <= '0;
      else if (imem_addr != prev_pc)
         since <= '0;
      else if (since != 3'd7)
         since <= since + 3'd1;
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      $past(rst) |-> (imem_addr == '0 && !done && !halted));

   // R8
   halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      halted |=> halted);

   // R9
   done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      done |=> done);

   // R9
   stop_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(done && halted));

   // R8
   stop_pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (done || halted) |=> $stable(imem_addr));

   // R7
   pc_spacing_chk: assert property (@(posedge clk) disable iff (rst)
      (imem_addr != prev_pc && !$past(rst)) |-> since >= 3'd4);
endmodule

bind mc8_core mc8_chk #(.PC_W(PC_W)) i_mc8_chk (
   .clk(clk), .rst(rst), .imem_addr(imem_addr), .done(done), .halted(halted)
);

// File: tb/test_mc8_core.sv
`timescale 1ns/1ps
module test_mc8_core;
   localparam int PC_W = 10;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic [PC_W:0]   prog_len = '0;
   logic [PC_W-1:0] imem_addr;
   logic [15:0]     imem_data;
   logic            dbg_mem_sel = 1'b0;
   logic [7:0]      dbg_addr = '0;
   logic [7:0]      dbg_data;
   logic            done, halted;

   logic [15:0] prog [1024];
   assign imem_data = prog[imem_addr];

   always #10 clk = ~clk;

   mc8_core i_mc8_core (
      .clk(clk), .rst(rst), .prog_len(prog_len), .imem_addr(imem_addr),
      .imem_data(imem_data), .dbg_mem_sel(dbg_mem_sel), .dbg_addr(dbg_addr),
      .dbg_data(dbg_data), .done(done), .halted(halted)
   );

   int n_chk = 0;
   int n_err = 0;
   int tick  = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      tick++;
      if (tick > 150000) begin
         chk(1'b0, "watchdog", tick, 150000);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   // reference model state
   logic [7:0] rreg [16];
   logic [7:0] rmem [256];

   task automatic ref_run(input int len, output int n_exec, output bit r_halt, output int r_pc);
      int pc = 0;
      n_exec = 0;
      r_halt = 1'b0;
      for (int i = 0; i < 16; i++) rreg[i] = '0;
      for (int i = 0; i < 256; i++) rmem[i] = '0;
      while (pc < len && n_exec < 10000) begin
         logic [15:0] w;
         logic [3:0]  op, rn, rm;
         logic [7:0]  sb;
         w  = prog[pc];
         op = w[15:12]; rn = w[11:8]; sb = w[7:0]; rm = sb[7:4];
         if (op > 4'h6) begin
            r_halt = 1'b1;
            break;
         end
         n_exec++;
         case (op)
            4'h0: rreg[rn] = rmem[sb];
            4'h1: rmem[sb] = rreg[rn];
            4'h2: rmem[rreg[rn]] = rreg[rm];
            4'h3: rreg[rn] = sb;
            4'h4: rreg[rn] = rreg[rn] + rreg[rm];
            4'h5: rreg[rn] = rreg[rn] - rreg[rm];
            default: ;
         endcase
         if (op == 4'h6 && rreg[rn] == 8'h00)
            pc = (pc + int'($signed(sb)) + 1024) % 1024;
         else
            pc = pc + 1;
      end
      r_pc = pc;
   endtask

   // scoreboard
   typedef struct packed {
      logic       mem;
      logic [7:0] addr;
      logic [7:0] val;
   } item_t;
   item_t sb_q[$];
   string cur_req = "";

   task automatic push_exp(input logic mem, input logic [7:0] addr, input logic [7:0] val);
      item_t it;
      it.mem = mem; it.addr = addr; it.val = val;
      sb_q.push_back(it);
   endtask

   // monitor: one debug read per cycle (R10)
   initial begin
      forever begin
         @(negedge clk);
         if (sb_q.size() != 0) begin
            item_t it;
            it = sb_q.pop_front();
            dbg_mem_sel = it.mem;
            dbg_addr    = it.addr;
            #2;
            chk(dbg_data == it.val,
                $sformatf("%s R10 %s[%0h]", cur_req, it.mem ? "mem" : "reg", it.addr),
                dbg_data, it.val);
         end
      end
   end

   task automatic clear_prog();
      for (int i = 0; i < 1024; i++) prog[i] = 16'h0000;
   endtask

   task automatic run_case(input string req, input int len);
      int  n_exec, r_pc, cyc, exp_cyc;
      bit  r_halt;
      cur_req = req;
      @(negedge clk);
      rst = 1'b1;
      prog_len = (PC_W+1)'(len);
      ref_run(len, n_exec, r_halt, r_pc);
      repeat (2) @(negedge clk);
      rst = 1'b0;
      cyc = 0;
      while (cyc < 20000) begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
         if (done || halted) break;
      end
      exp_cyc = r_halt ? 5 * n_exec + 2 : 5 * n_exec + 1;
      // R7 cycle count, R8/R9 stop kind
      chk(cyc == exp_cyc, {req, " R7 cycles"}, cyc, exp_cyc);
      chk(halted == r_halt, {req, " R8 halted"}, halted, r_halt);
      chk(done == !r_halt, {req, " R9 done"}, done, !r_halt);
      chk(imem_addr == PC_W'(r_pc), {req, " R6 final pc"}, imem_addr, r_pc);
      for (int i = 0; i < 16; i++) push_exp(1'b0, 8'(i), rreg[i]);
      for (int i = 0; i < 256; i++) push_exp(1'b1, 8'(i), rmem[i]);
      wait (sb_q.size() == 0);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      clear_prog();
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1;
      // R1 reset state, sampled before the first edge after release
      chk(imem_addr == '0, "R1 pc", imem_addr, 0);
      chk(done == 1'b0, "R1 done", done, 0);
      chk(halted == 1'b0, "R1 halted", halted, 0);

      // summation loop: R2 R3 R4 R5 R6 (taken backward and forward, not taken)
      clear_prog();
      prog[0]  = 16'h3000; prog[1]  = 16'h310A; prog[2]  = 16'h3201;
      prog[3]  = 16'h3300; prog[4]  = 16'h6104; prog[5]  = 16'h4010;
      prog[6]  = 16'h5120; prog[7]  = 16'h63FD; prog[8]  = 16'h1020;
      prog[9]  = 16'h0520; prog[10] = 16'h3640; prog[11] = 16'h2650;
      run_case("R2 R3 R4 R6 sum", 12);

      // wrap arithmetic R5, store to top byte R3, branch not taken R6
      clear_prog();
      prog[0]  = 16'h37F0; prog[1]  = 16'h3820; prog[2]  = 16'h4780;
      prog[3]  = 16'h3905; prog[4]  = 16'h3A07; prog[5]  = 16'h59A0;
      prog[6]  = 16'h1750; prog[7]  = 16'h1951; prog[8]  = 16'h6705;
      prog[9]  = 16'h3B33; prog[10] = 16'h3CFF; prog[11] = 16'h2CB0;
      prog[12] = 16'h4CC0;
      run_case("R5 R3 wrap", 13);

      // branch past the program length ends with done, pc = 6 (R6 R9)
      clear_prog();
      prog[0] = 16'h3000; prog[1] = 16'h6005; prog[2] = 16'h3DAA; prog[3] = 16'h3DBB;
      run_case("R6 R9 jump out", 4);

      // illegal opcode 0x7 after two legal ones (R8)
      clear_prog();
      prog[0] = 16'h3E5A; prog[1] = 16'h3F01; prog[2] = 16'h7F00; prog[3] = 16'h3E00;
      run_case("R8 illegal 0x7", 4);
      repeat (20) @(negedge clk);
      chk(halted == 1'b1, "R8 halted sticky", halted, 1);
      chk(imem_addr == 10'd2, "R8 pc held", imem_addr, 2);

      // illegal opcode 0xF as first instruction (R8)
      clear_prog();
      prog[0] = 16'hFFFF;
      run_case("R8 illegal 0xF", 1);

      // empty program after previous runs: everything cleared by reset (R1 R9)
      clear_prog();
      run_case("R1 R9 empty", 0);
      repeat (10) @(negedge clk);
      chk(done == 1'b1, "R9 done sticky", done, 1);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule